// File: doc/BRIEF.md
# PLL Control Register Block

This block is the software-facing control and status register pair for a clock-generator PLL. A CPU on a simple synchronous bus writes two byte-wide registers: a control register (PLL enable, interrupt enable, interrupt flag, base-clock select, automatic-bandwidth mode, and a read-only lock status) and a frequency register (a 4-bit multiplier code and a 4-bit VCO range code). The block turns those fields into the signals the analog side needs. These are the PLL enable, the decoded multiplier value N, the range code and the clock-source select. It also drives a toggle divider that models the VCO clock divided by two.

The frequency fields cannot be changed while the PLL is enabled. A range code of zero forces the VCO clock off as the base-clock source. The lock indicator from the analog lock detector passes through a two-flop synchronizer. A two-state tracker then follows it: state `LK_OUT` (not locked) moves to `LK_IN` when the synchronized lock rises, and `LK_IN` moves back to `LK_OUT` when it falls. Each of these two transitions produces a one-cycle lock-change event. In automatic mode that event sets the interrupt flag.

Top module: `pll_ctrl_regs`

Register map. The control register is at address 0. Its bits are:
- bit 7: PLL enable.
- bit 6: interrupt enable.
- bit 5: interrupt flag (write 1 to clear).
- bit 4: base-clock select.
- bit 3: automatic mode.
- bit 2: lock status (read-only).
- bits 1:0: read as 0.

The frequency register is at address 1. Bits 7:4 hold the range code and bits 3:0 hold the multiplier code. Reads are combinational on `bus_addr`.

## Requirements
- R1: After reset the control register reads 0x00 (lock input low), the frequency register reads 0x60 (range code 6, multiplier code 0), and `irq` is low.
- R2: A write to the frequency register leaves the multiplier code (bits 3:0) unchanged while the PLL enable bit (control bit 7) is 1.
- R3: A write to the frequency register leaves the range code (bits 7:4) unchanged while the PLL enable bit is 1; with the enable at 0 the write takes effect.
- R4: When the range code is 0, the base-clock select (control bit 4) is cleared within one cycle, and a control write setting bit 4 leaves it at 0.
- R5: `mult_n` presents N decoded from the multiplier code: codes 0 and 1 give 1, codes 2 to 15 give the code itself.
- R6: With automatic mode (control bit 3) at 1, both a rising and a falling lock input set the flag (control bit 5), visible three cycles after the input changes. Control bit 2 shows the synchronized lock state.
- R7: The flag sets regardless of the interrupt enable (bit 6); `irq` is high exactly when the flag, the interrupt enable and automatic mode are all 1.
- R8: With automatic mode at 0, `irq` stays low, the flag reads as 0, and lock changes do not set it.
- R9: Writing control bit 5 as 1 clears the flag, except when a lock-change event falls in the same cycle, in which case the flag stays set.
- R10: `vco_sel` equals the base-clock select bit. `vco_half` toggles on every cycle with `vco_ce` high, holds otherwise, and resets to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register address (0 control, 1 frequency) |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| lock_raw | input | 1 | Asynchronous lock indication from the lock detector |
| vco_ce | input | 1 | Enable marking a VCO clock edge for the divider |
| pll_on | output | 1 | PLL enable to the analog block |
| mult_n | output | MULT_W | Decoded frequency multiplier N |
| range_code | output | RANGE_W | VCO range code |
| vco_sel | output | 1 | Selects VCO/2 as the base clock when high |
| vco_half | output | 1 | Toggle divider output (VCO clock divided by two) |
| irq | output | 1 | CPU interrupt request |

## Verification
The hardest case to reach from the ports is R9: a flag-clearing write arriving on exactly the clock edge where a synchronized lock change reaches the tracker. The bench gets there by counting register stages. It flips `lock_raw` half a cycle before an edge and lets two edges pass through the synchronizer. It then drives the write-1-to-clear so that it is sampled on the third edge, the same edge that registers the lock event. The flag must survive, and a later plain clear must remove it. The range-zero lockout (R4) likewise needs a specific ordering: the PLL is disabled, range zero is written, and only then is the select bit attempted.

// File: rtl/pll_ctrl_pkg.sv
package pll_ctrl_pkg;
    localparam int DATA_W = 8;

    // control register bit positions
    localparam int CB_PLL_EN = 7;
    localparam int CB_IRQ_EN = 6;
    localparam int CB_FLAG   = 5;
    localparam int CB_BCLK   = 4;
    localparam int CB_AUTO   = 3;
    localparam int CB_LOCKED = 2;

    typedef enum logic {
        LK_OUT = 1'b0,
        LK_IN  = 1'b1
    } lock_state_e;
endpackage

// File: rtl/pll_lock_sync.sv
module pll_lock_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], din};
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/pll_lock_fsm.sv
module pll_lock_fsm
    import pll_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lock_s,
    output logic locked,
    output logic lock_evt
);
    lock_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_OUT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        lock_evt = 1'b0;
        unique case (state_q)
            LK_OUT: if (lock_s) begin
                state_d  = LK_IN;
                lock_evt = 1'b1;
            end
            LK_IN: if (!lock_s) begin
                state_d  = LK_OUT;
                lock_evt = 1'b1;
            end
        endcase
    end

    assign locked = (state_q == LK_IN);
endmodule

// File: rtl/pll_mult_dec.sv
module pll_mult_dec #(
    parameter int W = 4
) (
    input  logic [W-1:0] code,
    output logic [W-1:0] n
);
    localparam logic [W-1:0] ONE = W'(1);

    always_comb begin
        if (code <= ONE) n = ONE;
        else             n = code;
    end
endmodule

// File: rtl/pll_vco_div.sv
module pll_vco_div (
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    output logic half
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  half <= 1'b0;
        else if (ce) half <= ~half;
    end
endmodule

// File: rtl/pll_ctrl_regs.sv
module pll_ctrl_regs
    import pll_ctrl_pkg::*;
#(
    parameter int ADDR_W      = 1,
    parameter int MULT_W      = 4,
    parameter int RANGE_W     = 4,
    parameter int SYNC_STAGES = 2,
    parameter int RANGE_RESET = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic               lock_raw,
    input  logic               vco_ce,
    output logic               pll_on,
    output logic [MULT_W-1:0]  mult_n,
    output logic [RANGE_W-1:0] range_code,
    output logic               vco_sel,
    output logic               vco_half,
    output logic               irq
);
    localparam logic [ADDR_W-1:0]  A_CTRL  = '0;
    localparam logic [ADDR_W-1:0]  A_FREQ  = ADDR_W'(1);
    localparam logic [RANGE_W-1:0] RNG_RST = RANGE_W'(RANGE_RESET);

    logic pll_en_q, irq_en_q, flag_q, bclk_q, auto_q;
    logic [MULT_W-1:0]  mult_q;
    logic [RANGE_W-1:0] range_q;
    logic lock_s, locked, lock_evt;
    logic wr_ctrl, wr_freq;

    assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
    assign wr_freq = bus_wr && (bus_addr == A_FREQ);

    pll_lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(lock_raw), .dout(lock_s)
    );

    pll_lock_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .lock_s(lock_s),
        .locked(locked), .lock_evt(lock_evt)
    );

    pll_mult_dec #(.W(MULT_W)) u_dec (
        .code(mult_q), .n(mult_n)
    );

    pll_vco_div u_div (
        .clk(clk), .rst_n(rst_n), .ce(vco_ce), .half(vco_half)
    );

    // control fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pll_en_q <= 1'b0;
            irq_en_q <= 1'b0;
            auto_q   <= 1'b0;
        end else if (wr_ctrl) begin
            pll_en_q <= bus_wdata[CB_PLL_EN];
            irq_en_q <= bus_wdata[CB_IRQ_EN];
            auto_q   <= bus_wdata[CB_AUTO];
        end
    end

    // base-clock select, blocked while range is zero
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                bclk_q <= 1'b0;
        else if (range_q == '0)    bclk_q <= 1'b0;
        else if (wr_ctrl)          bclk_q <= bus_wdata[CB_BCLK];
    end

    // interrupt flag: lock event wins over write-1-to-clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              flag_q <= 1'b0;
        else if (!auto_q)                        flag_q <= 1'b0;
        else if (lock_evt)                       flag_q <= 1'b1;
        else if (wr_ctrl && bus_wdata[CB_FLAG])  flag_q <= 1'b0;
    end

    // frequency fields, locked while the PLL runs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mult_q  <= '0;
            range_q <= RNG_RST;
        end else if (wr_freq && !pll_en_q) begin
            mult_q  <= bus_wdata[MULT_W-1:0];
            range_q <= bus_wdata[MULT_W +: RANGE_W];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CTRL) begin
            bus_rdata[CB_PLL_EN] = pll_en_q;
            bus_rdata[CB_IRQ_EN] = irq_en_q;
            bus_rdata[CB_FLAG]   = flag_q & auto_q;
            bus_rdata[CB_BCLK]   = bclk_q;
            bus_rdata[CB_AUTO]   = auto_q;
            bus_rdata[CB_LOCKED] = locked;
        end else if (bus_addr == A_FREQ) begin
            bus_rdata = {range_q, mult_q};
        end
    end

    assign pll_on     = pll_en_q;
    assign range_code = range_q;
    assign vco_sel    = bclk_q;
    assign irq        = flag_q & irq_en_q & auto_q;
endmodule

module pll_ctrl_chk #(
    parameter int ADDR_W  = 1,
    parameter int MULT_W  = 4,
    parameter int RANGE_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               pll_on,
    input logic [MULT_W-1:0]  mult_n,
    input logic [RANGE_W-1:0] range_code,
    input logic               vco_sel,
    input logic               vco_ce,
    input logic               vco_half,
    input logic               irq,
    input logic               auto_q,
    input logic               irq_en_q
);
    localparam logic [ADDR_W-1:0] A_FREQ = ADDR_W'(1);

    AST_MULT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_on && bus_wr && bus_addr == A_FREQ) |=> $stable(mult_n)); // R2
    AST_RANGE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_on && bus_wr && bus_addr == A_FREQ) |=> $stable(range_code)); // R3
    AST_RANGE_ZERO_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (range_code == '0) |=> !vco_sel); // R4
    AST_MULT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        mult_n != '0); // R5
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (auto_q && irq_en_q)); // R7
    AST_MANUAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_q |-> !irq); // R8
    AST_DIV_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        vco_ce |=> (vco_half != $past(vco_half))); // R10
endmodule

bind pll_ctrl_regs pll_ctrl_chk #(
    .ADDR_W(ADDR_W), .MULT_W(MULT_W), .RANGE_W(RANGE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .pll_on(pll_on), .mult_n(mult_n), .range_code(range_code),
    .vco_sel(vco_sel), .vco_ce(vco_ce), .vco_half(vco_half), .irq(irq),
    .auto_q(auto_q), .irq_en_q(irq_en_q)
);

// File: tb/pll_ctrl_regs_bench.sv
`timescale 1ns/1ps
module pll_ctrl_regs_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [0:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       lock_raw = 1'b0;
    logic       vco_ce = 1'b0;
    logic       pll_on, vco_sel, vco_half, irq;
    logic [3:0] mult_n, range_code;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pll_ctrl_regs u_pll_ctrl_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lock_raw(lock_raw),
        .vco_ce(vco_ce), .pll_on(pll_on), .mult_n(mult_n),
        .range_code(range_code), .vco_sel(vco_sel), .vco_half(vco_half),
        .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // change the lock input and wait until the flag has registered
    task automatic set_lock(input logic v);
        @(negedge clk);
        lock_raw = v;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(1'b0, d); check("R1 ctrl", d, 8'h00);
        rd(1'b1, d); check("R1 freq", d, 8'h60);
        check("R1 irq", irq, 0);
        check("R5 reset N", mult_n, 1);
    endtask

    task automatic t_mult_decode();
        for (int c = 0; c < 16; c++) begin
            wr(1'b1, {4'h6, 4'(c)});
            check("R5 decode", mult_n, (c < 2) ? 1 : c);
        end
    endtask

    task automatic t_protect();
        logic [7:0] d;
        wr(1'b1, 8'h35);
        wr(1'b0, 8'h80);
        check("R2 pll_on", pll_on, 1);
        wr(1'b1, 8'h9C);
        rd(1'b1, d);
        check("R2 mult held", d[3:0], 4'h5);
        check("R3 range held", d[7:4], 4'h3);
        wr(1'b0, 8'h00);
        wr(1'b1, 8'h9C);
        rd(1'b1, d);
        check("R3 write when off", d, 8'h9C);
    endtask

    task automatic t_range_zero();
        logic [7:0] d;
        wr(1'b0, 8'h10);
        check("R10 vco_sel set", vco_sel, 1);
        wr(1'b1, 8'h04);
        @(negedge clk);
        check("R4 cleared", vco_sel, 0);
        wr(1'b0, 8'h10);
        rd(1'b0, d);
        check("R4 blocked", d[4], 0);
        check("R10 vco_sel low", vco_sel, 0);
        wr(1'b1, 8'h64);
    endtask

    task automatic t_divider();
        logic a, b;
        @(negedge clk); vco_ce = 1'b1;
        @(negedge clk); a = vco_half;
        @(negedge clk); b = vco_half;
        check("R10 toggle", b, !a);
        vco_ce = 1'b0;
        @(negedge clk); a = vco_half;
        @(negedge clk); b = vco_half;
        check("R10 hold", b, a);
    endtask

    task automatic t_auto_lock();
        logic [7:0] d;
        wr(1'b0, 8'h08);
        set_lock(1'b1);
        rd(1'b0, d);
        check("R6 rise sets flag", d, 8'h2C);
        check("R7 no irq without enable", irq, 0);
        wr(1'b0, 8'h68);
        rd(1'b0, d);
        check("R9 w1c clear", d, 8'h4C);
        check("R7 irq low after clear", irq, 0);
        set_lock(1'b0);
        rd(1'b0, d);
        check("R6 fall sets flag", d, 8'h68);
        check("R7 irq high", irq, 1);
    endtask

    task automatic t_auto_off();
        logic [7:0] d;
        wr(1'b0, 8'h40);
        rd(1'b0, d);
        check("R8 flag reads 0", d, 8'h40);
        check("R8 irq low", irq, 0);
        set_lock(1'b1);
        rd(1'b0, d);
        check("R8 lock change ignored", d, 8'h44);
        check("R8 irq stays low", irq, 0);
    endtask

    task automatic t_w1c_priority();
        wr(1'b0, 8'h48);
        check("R9 start clear", irq, 0);
        @(negedge clk); lock_raw = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        bus_addr = 1'b0; bus_wdata = 8'h68; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk); bus_wr = 1'b0;
        check("R9 event wins", irq, 1);
        wr(1'b0, 8'h68);
        check("R9 later clear", irq, 0);
    endtask

    task automatic finish_up();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual 0x0 expected 0x1");
        finish_up();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_mult_decode();
        t_protect();
        t_range_zero();
        t_divider();
        t_auto_lock();
        t_auto_off();
        t_w1c_priority();
        finish_up();
    end
endmodule